// File: doc/BRIEF.md
# Processor Doorbell Message Dispatcher

This block turns doorbell commands into per-processor pending bits for a cluster of `N_CPU` processors. Each processor can issue a send and a clear, each carrying a 32-bit operand. The operand holds a message type in bits [31:27], a broadcast flag in bit 26 and a target tag in bits [13:0].

A send of type 0 or type 1 targets every processor whose ID register equals the tag, or every processor when broadcast is set. For a type 0 send it sets that processor's normal pending bit, for a type 1 send its critical pending bit, and it pulses that processor's hard-interrupt request for one cycle. A clear of type 0 or type 1 removes the matching bit from the issuing processor only. Guest message types and unused codes do nothing. The ID registers are loaded through a write port. Choosing which pending interrupt to take is left to the consumer.

Top module: `doorbell_dispatch`

## Requirements
- R1: After reset, all pending bits and interrupt requests are 0, and the ID register of processor i holds i.
- R2: A send with type field (bits [31:27]) equal to 0 sets `pend_norm` of every targeted processor at the next clock edge.
- R3: A send with type field equal to 1 sets `pend_crit` of every targeted processor at the next clock edge.
- R4: With the broadcast flag (bit 26) set, every processor is targeted. With it clear, exactly the processors whose ID register equals bits [13:0] are targeted, and there may be several.
- R5: In the cycle after a type 0 or type 1 send, `hard_irq` is high for exactly the targeted processors. It is low in every other cycle.
- R6: Type codes 2 (guest normal), 3 (guest critical), 4 (guest machine check) and all codes above 4 change no pending bit and raise no request, whether sent or cleared.
- R7: A clear with type 0 or 1 removes only the matching bit of processor `clr_src`. The broadcast flag and the tag are ignored for a clear.
- R8: When a send and a clear act on the same bit in the same cycle, the bit ends up set.
- R9: An ID register write takes effect at the next edge. A send in the same cycle still matches against the old ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | Send command present |
| snd_op | input | 32 | Send operand |
| clr_valid | input | 1 | Clear command present |
| clr_src | input | IDX_W | Processor issuing the clear |
| clr_op | input | 32 | Clear operand |
| id_we | input | 1 | ID register write enable |
| id_sel | input | IDX_W | ID register selected for the write |
| id_wdata | input | TAG_W | New ID value |
| pend_norm | output | N_CPU | Normal doorbell pending, one bit per processor |
| pend_crit | output | N_CPU | Critical doorbell pending, one bit per processor |
| hard_irq | output | N_CPU | One-cycle hard-interrupt request per processor |

## Verification
The bench programs several processors with the same ID to show that a tag match fans out to all of them. A design that stopped at the first match would leave bits unset.

It sends a broadcast whose tag matches nobody. A design that ignored the flag would set nothing.

It issues a send and a clear on the same bit together. A clear-priority design would drop that bit.

It issues a clear with broadcast set and a tag matching other processors. A design that reused the send targeting would wipe bits on processors other than the issuer.

Finally, it writes an ID in the same cycle as a send. A design with a write-through path would match against the new value.

// File: rtl/doorbell_dispatch.sv
module doorbell_dispatch #(
  parameter int N_CPU = 4,
  parameter int TAG_W = 14,
  parameter int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snd_valid,
  input  logic [31:0]      snd_op,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_src,
  input  logic [31:0]      clr_op,
  input  logic             id_we,
  input  logic [IDX_W-1:0] id_sel,
  input  logic [TAG_W-1:0] id_wdata,
  output logic [N_CPU-1:0] pend_norm,
  output logic [N_CPU-1:0] pend_crit,
  output logic [N_CPU-1:0] hard_irq
);
  localparam logic [4:0] KIND_NORM = 5'd0;
  localparam logic [4:0] KIND_CRIT = 5'd1;

  logic [TAG_W-1:0] cpu_id [N_CPU];
  logic [N_CPU-1:0] hit;
  logic [N_CPU-1:0] src_1h;

  wire snd_norm = snd_valid && (snd_op[31:27] == KIND_NORM);
  wire snd_crit = snd_valid && (snd_op[31:27] == KIND_CRIT);
  wire clr_norm = clr_valid && (clr_op[31:27] == KIND_NORM);
  wire clr_crit = clr_valid && (clr_op[31:27] == KIND_CRIT);
  wire bcast    = snd_op[26];
  wire [TAG_W-1:0] tag = snd_op[TAG_W-1:0];

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign hit[i]    = bcast || (cpu_id[i] == tag);
    assign src_1h[i] = (clr_src == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)
        cpu_id[i] <= TAG_W'(i);
      else if (id_we && id_sel == IDX_W'(i))
        cpu_id[i] <= id_wdata;
    end
  end

  wire [N_CPU-1:0] set_norm = snd_norm ? hit : '0;
  wire [N_CPU-1:0] set_crit = snd_crit ? hit : '0;
  wire [N_CPU-1:0] kill_norm = clr_norm ? src_1h : '0;
  wire [N_CPU-1:0] kill_crit = clr_crit ? src_1h : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_norm <= '0;
      pend_crit <= '0;
      hard_irq  <= '0;
    end else begin
      pend_norm <= (pend_norm & ~kill_norm) | set_norm;
      pend_crit <= (pend_crit & ~kill_crit) | set_crit;
      hard_irq  <= set_norm | set_crit;
    end
  end
endmodule

// File: rtl/doorbell_dispatch_chk.sv
module doorbell_dispatch_chk #(
  parameter int N_CPU = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snd_valid,
  input logic [31:0]      snd_op,
  input logic             clr_valid,
  input logic [IDX_W-1:0] clr_src,
  input logic [31:0]      clr_op,
  input logic [N_CPU-1:0] pend_norm,
  input logic [N_CPU-1:0] pend_crit,
  input logic [N_CPU-1:0] hard_irq
);
  wire snd_other = snd_op[31:27] > 5'd1;

  a_r2_bcast_sets_norm: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid && snd_op[31:27] == 5'd0 && snd_op[26] |=> &pend_norm);

  a_r5_irq_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    |hard_irq |-> ((hard_irq & ~(pend_norm | pend_crit)) == '0));

  a_r6_guest_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid && snd_other && !clr_valid |=>
      $stable(pend_norm) && $stable(pend_crit) && hard_irq == '0);

  a_r7_clear_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid && !snd_valid |=>
      ((pend_norm & ~$past(pend_norm)) == '0) &&
      ($countones($past(pend_norm) & ~pend_norm) <= 1));

  a_r8_send_wins: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid && snd_op[31:27] == 5'd0 && snd_op[26] &&
    clr_valid && clr_op[31:27] == 5'd0 |=> pend_norm[$past(clr_src)]);
endmodule

bind doorbell_dispatch doorbell_dispatch_chk #(.N_CPU(N_CPU), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_op(snd_op),
  .clr_valid(clr_valid), .clr_src(clr_src), .clr_op(clr_op),
  .pend_norm(pend_norm), .pend_crit(pend_crit), .hard_irq(hard_irq));

// File: tb/doorbell_dispatch_tb.sv
`timescale 1ns/1ps
module doorbell_dispatch_tb;
  localparam int N = 4;
  localparam int IW = 2;
  localparam int TW = 14;

  logic clk = 0, rst_n = 0;
  logic snd_valid = 0, clr_valid = 0, id_we = 0;
  logic [31:0] snd_op = 0, clr_op = 0;
  logic [IW-1:0] clr_src = 0, id_sel = 0;
  logic [TW-1:0] id_wdata = 0;
  logic [N-1:0] pend_norm, pend_crit, hard_irq;

  int n_vec = 0, n_bad = 0;
  logic [N-1:0] m_norm, m_crit, m_irq;
  logic [TW-1:0] m_id [N];

  always #4 clk = ~clk;

  doorbell_dispatch #(.N_CPU(N), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_op(snd_op),
    .clr_valid(clr_valid), .clr_src(clr_src), .clr_op(clr_op),
    .id_we(id_we), .id_sel(id_sel), .id_wdata(id_wdata),
    .pend_norm(pend_norm), .pend_crit(pend_crit), .hard_irq(hard_irq));

  function automatic logic [31:0] mk(input int kind, input bit bc, input int tg);
    return {5'(kind), bc, 12'd0, 14'(tg)};
  endfunction

  function automatic logic [N-1:0] targets(input logic [31:0] op);
    logic [N-1:0] t;
    for (int i = 0; i < N; i++) t[i] = op[26] || (m_id[i] == op[TW-1:0]);
    return t;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_norm = 0; m_crit = 0; m_irq = 0;
    for (int i = 0; i < N; i++) m_id[i] = TW'(i);
  endtask

  task automatic step(input string req);
    logic [N-1:0] t, sn, sc, kn, kc;
    t = targets(snd_op);
    sn = (snd_valid && snd_op[31:27] == 0) ? t : '0;
    sc = (snd_valid && snd_op[31:27] == 1) ? t : '0;
    kn = (clr_valid && clr_op[31:27] == 0) ? (N'(1) << clr_src) : '0;
    kc = (clr_valid && clr_op[31:27] == 1) ? (N'(1) << clr_src) : '0;
    @(posedge clk);
    m_norm = (m_norm & ~kn) | sn;
    m_crit = (m_crit & ~kc) | sc;
    m_irq  = sn | sc;
    if (id_we) m_id[id_sel] = id_wdata;
    @(negedge clk);
    chk(req, pend_norm, m_norm);
    chk(req, pend_crit, m_crit);
    chk(req, hard_irq, m_irq);
    snd_valid = 0; clr_valid = 0; id_we = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'h1d0b));
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    step("R1 reset state");
    // R1: reset IDs: tag 2 hits only processor 2
    snd_valid = 1; snd_op = mk(0, 0, 2); step("R1 R4 reset id");
    // R2 broadcast normal
    snd_valid = 1; snd_op = mk(0, 1, 9); step("R2 R4 broadcast");
    // R7 clear with broadcast and tag is local only
    clr_valid = 1; clr_src = 1; clr_op = mk(0, 1, 3); step("R7 local clear");
    // R3 critical by tag
    snd_valid = 1; snd_op = mk(1, 0, 3); step("R3 critical tag");
    // R6 guest types
    snd_valid = 1; snd_op = mk(2, 1, 0); step("R6 guest normal");
    snd_valid = 1; snd_op = mk(3, 1, 0); step("R6 guest critical");
    snd_valid = 1; snd_op = mk(4, 1, 0); clr_valid = 1; clr_src = 0; clr_op = mk(4, 0, 0);
    step("R6 guest mcheck");
    // R9 ID write same cycle as send: old id used
    id_we = 1; id_sel = 0; id_wdata = 7; snd_valid = 1; snd_op = mk(1, 0, 7); step("R9 old id");
    id_we = 1; id_sel = 1; id_wdata = 7; step("R9 write");
    snd_valid = 1; snd_op = mk(1, 0, 7); step("R4 R5 multi match");
    // R8 send and clear same bit
    snd_valid = 1; snd_op = mk(0, 1, 0); clr_valid = 1; clr_src = 3; clr_op = mk(0, 0, 0);
    step("R8 send wins");
    step("R5 irq one cycle");
    for (int k = 0; k < 400; k++) begin
      r = $urandom_range(0, 9);
      snd_valid = $urandom_range(0, 1);
      snd_op = mk((r < 4) ? 0 : (r < 7) ? 1 : (r == 7) ? 3 : 31,
                  $urandom_range(0, 3) == 0, $urandom_range(0, 5));
      clr_valid = $urandom_range(0, 1);
      clr_src = IW'($urandom_range(0, N - 1));
      clr_op = mk($urandom_range(0, 2), $urandom_range(0, 1), $urandom_range(0, 5));
      id_we = ($urandom_range(0, 7) == 0);
      id_sel = IW'($urandom_range(0, N - 1));
      id_wdata = TW'($urandom_range(0, 5));
      step("R2 R3 R4 R5 R7 R8 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule